// File: doc/BRIEF.md
# Rotate-Right Execution Unit (32/64-bit)

This unit executes the rotate-right operations of a 64-bit integer pipeline. It receives the decoded instruction word, the source operand and the value of the register that can supply a variable amount. One clock later it returns the rotated result and a flag that says the instruction was a rotate. Rotates reuse the function codes of the logical right shifts. A single select field holds 00001 for a rotate and zero for the plain shift, so the unit also tells the two apart.

Four ways of giving the amount are covered:
- a 5-bit immediate;
- a 5-bit immediate with 32 added, for the 64-bit form only;
- the low five bits of a register, for the 32-bit form;
- the low six bits of a register, for the 64-bit form.

The 32-bit forms rotate the low word of the source and return it sign-extended to 64 bits. Any instruction that is not a rotate gives a zero result with the flag clear, and the neighbouring shift unit handles it.

Top module: `rotu_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, resValid, rotFlag and resData are all zero, even if opValid is high during reset.
- R2: A result appears exactly one clock after the operation: resValid is high in the cycle after a cycle with opValid high and low after a cycle with opValid low. Back-to-back operations give back-to-back results.
- R3: Instruction bits 31:26 = 000000, bits 5:0 = 000010 and bits 25:21 = 00001 is a 32-bit rotate by the immediate in bits 10:6. The result is srcVal[31:0] rotated right, sign-extended from its bit 31.
- R4: Bits 31:26 = 000000, bits 5:0 = 000110 and bits 10:6 = 00001 is a 32-bit rotate by amtVal[4:0]. All higher bits of amtVal are ignored.
- R5: Bits 31:26 = 000000, bits 5:0 = 111010 and bits 25:21 = 00001 is a 64-bit rotate of srcVal by the immediate in bits 10:6.
- R6: Bits 31:26 = 000000, bits 5:0 = 111110 and bits 25:21 = 00001 is a 64-bit rotate by the immediate in bits 10:6 plus 32, which covers amounts 32 to 63.
- R7: Bits 31:26 = 000000, bits 5:0 = 010110 and bits 10:6 = 00001 is a 64-bit rotate by amtVal[5:0]. All higher bits of amtVal are ignored.
- R8: The matching shift encodings give rotFlag = 0 and resData = 0. These are function codes 111010, 111110 and 000010 with bits 25:21 = 00000, and function codes 000110 and 010110 with bits 10:6 = 00000.
- R9: An effective amount of zero returns the source unchanged: all 64 bits for the 64-bit forms, and the sign-extended low word for the 32-bit forms.
- R10: A 32-bit rotate does not depend on srcVal[63:32].
- R11: rotFlag is 1 only for the five rotate encodings. Any other select value, other function code, or nonzero bits 31:26 gives rotFlag = 0 and resData = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Decoded instruction word |
| srcVal | input | 64 | Source operand to be rotated |
| amtVal | input | 64 | Register value that supplies the variable amount |
| resValid | output | 1 | Result is valid (one cycle after opValid) |
| rotFlag | output | 1 | The instruction was a rotate |
| resData | output | 64 | Rotated result, zero when not a rotate |

## Verification
Single-bit and asymmetric sources at small, large and zero amounts show whether the rotation goes the right way and whether bits wrap around the 32-bit or 64-bit boundary. Sources with a nonzero upper word, and amount registers with their high bits set, show whether the 32-bit forms ignore bits they must not see. The +32 form is tried at both ends of its range. Each rotate encoding is paired with the shift encoding that differs only in the select field, so a decoder that ignores that field fails. A stream of random operands mixing rotates and non-rotates is compared cycle by cycle against the bench model.

// File: rtl/rotu_pkg.sv
package rotu_pkg;
  localparam int INSTR_W = 32;
  localparam int SA_W    = 5;
  localparam int FN_W    = 6;

  localparam logic [FN_W-1:0] FN_ROT_IMM   = 6'b000010;
  localparam logic [FN_W-1:0] FN_ROT_VAR   = 6'b000110;
  localparam logic [FN_W-1:0] FN_DROT_IMM  = 6'b111010;
  localparam logic [FN_W-1:0] FN_DROT_P32  = 6'b111110;
  localparam logic [FN_W-1:0] FN_DROT_VAR  = 6'b010110;
  localparam logic [SA_W-1:0] SEL_ROTATE   = 5'b00001;

  typedef struct packed {
    logic rotEn;   // instruction is a rotate
    logic wide;    // 64-bit form
    logic useReg;  // amount comes from amtVal
    logic add32;   // add 32 to the immediate
  } rotCtrlT;
endpackage

// File: rtl/rotu_ctrl.sv
module rotu_ctrl
  import rotu_pkg::*;
(
  input  logic [5:0]      opField,
  input  logic [SA_W-1:0] rsField,
  input  logic [SA_W-1:0] saField,
  input  logic [FN_W-1:0] fnField,
  output rotCtrlT         ctrl
);
  logic special;
  logic immSel;
  logic varSel;

  assign special = (opField == 6'b000000);
  assign immSel  = (rsField == SEL_ROTATE);
  assign varSel  = (saField == SEL_ROTATE);

  always_comb begin
    ctrl = '0;
    if (special) begin
      unique case (fnField)
        FN_ROT_IMM:  if (immSel) begin ctrl.rotEn = 1'b1; end
        FN_ROT_VAR:  if (varSel) begin ctrl.rotEn = 1'b1; ctrl.useReg = 1'b1; end
        FN_DROT_IMM: if (immSel) begin ctrl.rotEn = 1'b1; ctrl.wide = 1'b1; end
        FN_DROT_P32: if (immSel) begin ctrl.rotEn = 1'b1; ctrl.wide = 1'b1; ctrl.add32 = 1'b1; end
        FN_DROT_VAR: if (varSel) begin ctrl.rotEn = 1'b1; ctrl.wide = 1'b1; ctrl.useReg = 1'b1; end
        default: ctrl = '0;
      endcase
    end
  end
endmodule

// File: rtl/rotu_barrel.sv
module rotu_barrel #(
  parameter int W = 64,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [AW+1];

  assign stg[0] = din;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stg[s+1] = amt[s] ? {stg[s][SH-1:0], stg[s][W-1:SH]} : stg[s];
  end

  assign dout = stg[AW];
endmodule

// File: rtl/rotu_dp.sv
module rotu_dp
  import rotu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HALF_W = 32,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int HAMT_W = $clog2(HALF_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  rotCtrlT           ctrl,
  input  logic [SA_W-1:0]   saField,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] amtVal,
  output logic              resValid,
  output logic              rotFlag,
  output logic [DATA_W-1:0] resData
);
  logic [AMT_W-1:0]  wideAmt;
  logic [HAMT_W-1:0] narrowAmt;
  logic [DATA_W-1:0] wideRes;
  logic [HALF_W-1:0] narrowRes;
  logic [DATA_W-1:0] narrowExt;
  logic [DATA_W-1:0] nextData;

  always_comb begin
    if (ctrl.useReg) begin
      wideAmt   = amtVal[AMT_W-1:0];
      narrowAmt = amtVal[HAMT_W-1:0];
    end else begin
      wideAmt   = AMT_W'(saField) + (ctrl.add32 ? AMT_W'(HALF_W) : AMT_W'(0));
      narrowAmt = saField[HAMT_W-1:0];
    end
  end

  rotu_barrel #(.W(DATA_W)) u_wide (
    .din (srcVal),
    .amt (wideAmt),
    .dout(wideRes)
  );

  rotu_barrel #(.W(HALF_W)) u_narrow (
    .din (srcVal[HALF_W-1:0]),
    .amt (narrowAmt),
    .dout(narrowRes)
  );

  assign narrowExt = {{(DATA_W-HALF_W){narrowRes[HALF_W-1]}}, narrowRes};

  always_comb begin
    if (opValid && ctrl.rotEn) nextData = ctrl.wide ? wideRes : narrowExt;
    else                       nextData = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      rotFlag  <= 1'b0;
      resData  <= '0;
    end else begin
      resValid <= opValid;
      rotFlag  <= opValid && ctrl.rotEn;
      resData  <= nextData;
    end
  end
endmodule

// File: rtl/rotu_top.sv
module rotu_top
  import rotu_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         opValid,
  input  logic [31:0]  instr,
  input  logic [63:0]  srcVal,
  input  logic [63:0]  amtVal,
  output logic         resValid,
  output logic         rotFlag,
  output logic [63:0]  resData
);
  rotCtrlT ctrl;

  rotu_ctrl u_ctrl (
    .opField(instr[31:26]),
    .rsField(instr[25:21]),
    .saField(instr[10:6]),
    .fnField(instr[5:0]),
    .ctrl   (ctrl)
  );

  rotu_dp #(.DATA_W(64), .HALF_W(32)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .opValid (opValid),
    .ctrl    (ctrl),
    .saField (instr[10:6]),
    .srcVal  (srcVal),
    .amtVal  (amtVal),
    .resValid(resValid),
    .rotFlag (rotFlag),
    .resData (resData)
  );
endmodule

// File: rtl/rotu_chk.sv
module rotu_chk (
  input logic        clk,
  input logic        rstN,
  input logic        opValid,
  input logic [31:0] instr,
  input logic [63:0] srcVal,
  input logic        resValid,
  input logic        rotFlag,
  input logic [63:0] resData
);
  logic narrowOp;
  logic wideImmOp;
  logic wideVarOp;
  logic shiftOp;

  assign narrowOp  = (instr[5:0] == 6'b000010) || (instr[5:0] == 6'b000110);
  assign wideImmOp = (instr[31:26] == 6'd0) && (instr[25:21] == 5'b00001) &&
                     (instr[5:0] == 6'b111010);
  assign wideVarOp = (instr[5:0] == 6'b010110) || (instr[5:0] == 6'b111110) || wideImmOp;
  assign shiftOp   = (instr[25:21] == 5'd0) &&
                     ((instr[5:0] == 6'b111010) || (instr[5:0] == 6'b111110));

  a_r2_latency_on: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);
  a_r2_latency_off: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resValid);
  a_r11_flag_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> !rotFlag);
  a_r8_zero_when_not_rotate: assert property (@(posedge clk) disable iff (!rstN)
    !rotFlag |-> (resData == 64'd0));
  a_r8_shift_not_rotate: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && shiftOp) |=> !rotFlag);
  a_r3_sign_extended: assert property (@(posedge clk) disable iff (!rstN)
    (rotFlag && $past(narrowOp)) |-> (resData[63:32] == {32{resData[31]}}));
  a_r5_bits_preserved: assert property (@(posedge clk) disable iff (!rstN)
    (rotFlag && $past(wideVarOp)) |-> ($countones(resData) == $countones($past(srcVal))));
  a_r9_zero_amount: assert property (@(posedge clk) disable iff (!rstN)
    (rotFlag && $past(wideImmOp) && ($past(instr[10:6]) == 5'd0)) |-> (resData == $past(srcVal)));
endmodule

bind rotu_top rotu_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .instr   (instr),
  .srcVal  (srcVal),
  .resValid(resValid),
  .rotFlag (rotFlag),
  .resData (resData)
);

// File: tb/rotu_top_tb.sv
`timescale 1ns/1ps
module rotu_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] srcVal = '0;
  logic [63:0] amtVal = '0;
  logic        resValid;
  logic        rotFlag;
  logic [63:0] resData;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rotu_top u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .instr(instr),
    .srcVal(srcVal), .amtVal(amtVal),
    .resValid(resValid), .rotFlag(rotFlag), .resData(resData)
  );

  function automatic logic [31:0] mk(input logic [4:0] rs, input logic [4:0] rt,
                                     input logic [4:0] rd, input logic [4:0] sa,
                                     input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, sa, fn};
  endfunction

  function automatic logic [63:0] rotr(input logic [63:0] x, input int w, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = x[(i + n) % w];
    return r;
  endfunction

  function automatic void model(input logic [31:0] ins, input logic [63:0] src,
                                input logic [63:0] amt, output logic rot,
                                output logic [63:0] res);
    logic [4:0] rs = ins[25:21];
    logic [4:0] sa = ins[10:6];
    int w = 0;
    int n = 0;
    rot = 1'b0;
    res = '0;
    if (ins[31:26] == 6'd0) begin
      if (ins[5:0] == 6'b000010 && rs == 5'd1)      begin w = 32; n = int'(sa); end
      else if (ins[5:0] == 6'b000110 && sa == 5'd1) begin w = 32; n = int'(amt % 32); end
      else if (ins[5:0] == 6'b111010 && rs == 5'd1) begin w = 64; n = int'(sa); end
      else if (ins[5:0] == 6'b111110 && rs == 5'd1) begin w = 64; n = int'(sa) + 32; end
      else if (ins[5:0] == 6'b010110 && sa == 5'd1) begin w = 64; n = int'(amt % 64); end
    end
    if (w == 64) begin
      rot = 1'b1;
      res = rotr(src, 64, n);
    end else if (w == 32) begin
      rot = 1'b1;
      res = rotr({32'd0, src[31:0]}, 32, n);
      for (int i = 32; i < 64; i++) res[i] = res[31];
    end
  endfunction

  task automatic compare(input logic ev, input logic er, input logic [63:0] ed, input string tag);
    checks++;
    if (resValid !== ev || rotFlag !== er || resData !== ed) begin
      errors++;
      $display("FAIL %s: got valid=%0b rot=%0b data=%h, expected valid=%0b rot=%0b data=%h",
               tag, resValid, rotFlag, resData, ev, er, ed);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] ins, input logic [63:0] src,
                      input logic [63:0] amt, input string tag);
    logic er;
    logic [63:0] ed;
    opValid = v; instr = ins; srcVal = src; amtVal = amt;
    model(ins, src, amt, er, ed);
    if (!v) begin er = 1'b0; ed = '0; end
    @(negedge clk);
    compare(v, er, ed, tag);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] r1;
    // R1: reset holds everything at zero even with opValid high
    opValid = 1'b1; instr = mk(5'd1, 5'd2, 5'd3, 5'd4, 6'b111010); srcVal = 64'hF0;
    repeat (3) @(negedge clk);
    compare(1'b0, 1'b0, 64'd0, "R1 during reset");
    opValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    compare(1'b0, 1'b0, 64'd0, "R1 after reset");

    // R3: 32-bit immediate rotate, sign-extension
    step(1, mk(5'd1, 5'd4, 5'd5, 5'd1, 6'b000010), 64'hFFFF_FFFF_8000_0001, 0, "R3 sa=1");
    // R10: upper word of source ignored
    step(1, mk(5'd1, 5'd4, 5'd5, 5'd4, 6'b000010), 64'h1234_5678_0000_00F0, 0, "R10 upper ignored");
    step(1, mk(5'd1, 5'd4, 5'd5, 5'd31, 6'b000010), 64'h0000_0000_4000_0000, 0, "R3 sa=31");
    // R4: variable 32-bit, high amount bits ignored
    step(1, mk(5'd9, 5'd4, 5'd5, 5'd1, 6'b000110), 64'h0000_0000_0000_000F, 64'hFFFF_FFFF_FFFF_FFE3, "R4 amt=3");
    step(1, mk(5'd9, 5'd4, 5'd5, 5'd1, 6'b000110), 64'h0000_0000_1234_5678, 64'h20, "R4 amt=32 wraps to 0");
    // R5
    step(1, mk(5'd1, 5'd4, 5'd5, 5'd8, 6'b111010), 64'h0123_4567_89AB_CDEF, 0, "R5 sa=8");
    step(1, mk(5'd1, 5'd4, 5'd5, 5'd31, 6'b111010), 64'h0000_0000_8000_0000, 0, "R5 sa=31");
    // R6
    step(1, mk(5'd1, 5'd4, 5'd5, 5'd0, 6'b111110), 64'h0123_4567_89AB_CDEF, 0, "R6 sa=0 means 32");
    step(1, mk(5'd1, 5'd4, 5'd5, 5'd31, 6'b111110), 64'h0000_0000_0000_0001, 0, "R6 sa=31 means 63");
    // R7
    step(1, mk(5'd7, 5'd4, 5'd5, 5'd1, 6'b010110), 64'h0000_0000_0000_0001, 64'hFF25, "R7 amt=37");
    step(1, mk(5'd7, 5'd4, 5'd5, 5'd1, 6'b010110), 64'hDEAD_BEEF_0BAD_F00D, 64'h40, "R7 R9 amt=64 wraps to 0");
    // R9
    step(1, mk(5'd1, 5'd4, 5'd5, 5'd0, 6'b111010), 64'hDEAD_BEEF_0BAD_F00D, 0, "R9 wide sa=0");
    step(1, mk(5'd1, 5'd4, 5'd5, 5'd0, 6'b000010), 64'h1111_2222_8765_4321, 0, "R9 narrow sa=0");
    // R8: matching shift encodings
    step(1, mk(5'd0, 5'd4, 5'd5, 5'd3, 6'b111010), 64'hFFFF, 0, "R8 dsrl form");
    step(1, mk(5'd0, 5'd4, 5'd5, 5'd3, 6'b111110), 64'hFFFF, 0, "R8 dsrl32 form");
    step(1, mk(5'd0, 5'd4, 5'd5, 5'd3, 6'b000010), 64'hFFFF, 0, "R8 srl form");
    step(1, mk(5'd3, 5'd4, 5'd5, 5'd0, 6'b000110), 64'hFFFF, 3, "R8 srlv form");
    step(1, mk(5'd3, 5'd4, 5'd5, 5'd0, 6'b010110), 64'hFFFF, 3, "R8 dsrlv form");
    // R11: other select values and nonzero major opcode
    step(1, mk(5'd2, 5'd4, 5'd5, 5'd3, 6'b111010), 64'hFFFF, 0, "R11 select=2");
    step(1, mk(5'd3, 5'd4, 5'd5, 5'd3, 6'b000110), 64'hFFFF, 3, "R11 var select=3");
    step(1, {6'b010000, 5'd1, 5'd4, 5'd5, 5'd3, 6'b111010}, 64'hFFFF, 0, "R11 opcode nonzero");
    step(1, mk(5'd1, 5'd4, 5'd5, 5'd3, 6'b000011), 64'hFFFF, 0, "R11 other function");
    // R2: idle gap then back-to-back
    step(0, mk(5'd1, 5'd4, 5'd5, 5'd3, 6'b111010), 64'hFFFF, 0, "R2 idle");
    step(1, mk(5'd1, 5'd4, 5'd5, 5'd4, 6'b111010), 64'hABCD, 0, "R2 first");
    step(1, mk(5'd1, 5'd4, 5'd5, 5'd12, 6'b111010), 64'hABCD, 0, "R2 second");

    // Mixed random stream
    for (int k = 0; k < 300; k++) begin
      logic [5:0] fns [6];
      logic [4:0] rsv;
      logic [4:0] sav;
      fns[0] = 6'b000010; fns[1] = 6'b000110; fns[2] = 6'b111010;
      fns[3] = 6'b111110; fns[4] = 6'b010110; fns[5] = 6'b000011;
      rsv = ($urandom % 4 == 0) ? 5'd0 : (($urandom % 2 == 0) ? 5'd1 : 5'($urandom));
      sav = 5'($urandom);
      if (fns[k % 6] == 6'b000110 || fns[k % 6] == 6'b010110)
        sav = ($urandom % 4 == 0) ? 5'd0 : 5'd1;
      r1 = {$urandom, $urandom};
      step(($urandom % 8) != 0, mk(rsv, 5'($urandom), 5'($urandom), sav, fns[k % 6]),
           r1, {$urandom, $urandom}, "R3 R4 R5 R6 R7 R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule